// File: doc/BRIEF.md
# Deglitched Retriggerable Reset/Fault Pulse Generator

This block drives a shared active-low reset/fault line through an open-drain style pull-low enable. Two sources can start a pulse: a hardware-reset level input, which first passes a synchronizer and must then stay high for a programmable number of time-base ticks before it is accepted, and a one-cycle fault strobe from a safety controller, which is accepted at once. While a pulse is running, each newly accepted event reloads the full width, so the pulse always lasts the full width measured from the latest event.

Timing is counted in ticks of an external time base, one cycle wide (for example a 1 ms strobe). The deglitch and pulse lengths are parameters in tick units, 10 and 57 by default. After a reset input has been accepted, it gives no further pulse while it stays high. It must first go low and then rise again before it can be accepted a second time.

Top module: `rstflt_pulse`

## Requirements
- R1: While `rst_n` is low and after its release, with no event accepted, `pull_en` is 0.
- R2: The synchronized `hw_level` input is accepted on the tick that completes `DEGLITCH_TICKS` consecutive ticks seen while it is high. `pull_en` is 1 in the cycle after that tick and stays 0 before it.
- R3: If the synchronized `hw_level` goes low before acceptance, the tick count is cleared, and a later high period needs a full `DEGLITCH_TICKS` ticks again.
- R4: After an accepted event, `pull_en` stays 1 until the `PULSE_TICKS`-th tick after the event. It is 0 in the cycle after that tick.
- R5: Once accepted, a `hw_level` that stays high produces no further pulse. Only a fall followed by a new qualified high period does.
- R6: A one-cycle `fault_stb` starts the same `PULSE_TICKS` pulse in the next cycle, with no deglitch. A strobe during a pulse restarts the full width.
- R7: An accepted `hw_level` event during a pulse reloads the full width. `pull_en` does not drop between the two pulses.
- R8: A fault strobe and an accepted `hw_level` event in the same cycle give one restart of `PULSE_TICKS` ticks, not a double-length pulse.
- R9: An event that lands in the same cycle as a tick loads the full width, and that tick is not counted against the new pulse.
- R10: `pull_en` = 1 means the pad is driven low (reset/fault asserted). `pull_en` = 0 means the pad is released (high impedance).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base strobe; all lengths count these |
| hw_level | input | 1 | Raw hardware-reset level, asynchronous to `clk` |
| fault_stb | input | 1 | One-cycle fault strobe from the safety controller |
| pull_en | output | 1 | 1 = pull the reset/fault pad low, 0 = release it |

## Verification
The assertions take it for granted that `tick` and `fault_stb` are one-cycle strobes in step with `clk`. They also assume that `hw_level` is allowed its synchronizer latency before any tick is counted against it. The bench drives every input on the falling clock edge and keeps each tick isolated, with a low cycle after it. After every change of `hw_level` it waits several cycles with no tick before counting begins, so that the tick counts in each requirement are exact. The bench's expected values come only from counting ticks since the last accepted event.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
   // state of the reset-input qualifier
   typedef enum logic {
      QS_ARMED = 1'b0,   // waiting for / counting a high period
      QS_SPENT = 1'b1    // accepted; waiting for the input to fall
   } qual_state_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/rfp_sync.sv
module rfp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_in};
         end
         assign d_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rfp_qualify.sv
module rfp_qualify
   import rfp_pkg::*;
#(
   parameter int unsigned DEGLITCH_TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic level,
   output logic accept
);
   localparam int unsigned CW = cnt_width(DEGLITCH_TICKS);
   localparam logic [CW-1:0] LAST = CW'(DEGLITCH_TICKS - 1);

   qual_state_t   state;
   logic [CW-1:0] cnt;

   assign accept = (state == QS_ARMED) && level && tick && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= QS_ARMED;
         cnt   <= '0;
      end else begin
         case (state)
            QS_ARMED: begin
               if (!level) begin
                  cnt <= '0;
               end else if (tick) begin
                  if (cnt == LAST) begin
                     state <= QS_SPENT;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               cnt <= '0;
               if (!level) state <= QS_ARMED;
            end
         endcase
      end
   end

   // R5
   accept_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept);
endmodule

// File: rtl/rfp_timer.sv
module rfp_timer
   import rfp_pkg::*;
#(
   parameter int unsigned PULSE_TICKS = 57
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic trig,
   output logic active
);
   localparam int unsigned PW = cnt_width(PULSE_TICKS);
   localparam logic [PW-1:0] FULL = PW'(PULSE_TICKS);

   logic [PW-1:0] remaining;

   always_ff @(posedge clk) begin
      if (!rst_n)                        remaining <= '0;
      else if (trig)                     remaining <= FULL;
      else if (tick && remaining != '0)  remaining <= remaining - 1'b1;
   end

   assign active = (remaining != '0);

   // R4
   trig_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> active);
   // R1
   rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(trig));
   // R4
   end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> $past(tick));
   // R9
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig && !tick) |=> $stable(remaining));
endmodule

// File: rtl/rstflt_pulse.sv
module rstflt_pulse #(
   parameter int unsigned DEGLITCH_TICKS = 10,
   parameter int unsigned PULSE_TICKS    = 57,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hw_level,
   input  logic fault_stb,
   output logic pull_en
);
   generate
      if (DEGLITCH_TICKS < 1) begin : g_bad_dg
         $error("DEGLITCH_TICKS must be at least 1");
      end
      if (PULSE_TICKS < 1) begin : g_bad_pw
         $error("PULSE_TICKS must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic lvl_sync;
   logic hw_accept;
   logic start;

   rfp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(hw_level), .d_out(lvl_sync));

   rfp_qualify #(.DEGLITCH_TICKS(DEGLITCH_TICKS)) u_qual (
      .clk(clk), .rst_n(rst_n), .tick(tick), .level(lvl_sync), .accept(hw_accept));

   // either source, or both at once, is one restart (R8)
   assign start = hw_accept | fault_stb;

   rfp_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .trig(start), .active(pull_en));

   // R6
   fault_drives_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_stb |=> pull_en);
endmodule

// File: tb/test_rstflt_pulse.sv
module test_rstflt_pulse;
   localparam int unsigned DG = 4;
   localparam int unsigned PW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic hw_level = 1'b0;
   logic fault_stb = 1'b0;
   logic pull_en;

   int checks = 0;
   int errors = 0;
   logic hold_mon = 1'b1;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   rstflt_pulse #(.DEGLITCH_TICKS(DG), .PULSE_TICKS(PW), .SYNC_STAGES(2)) i_rstflt_pulse (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hw_level(hw_level),
      .fault_stb(fault_stb), .pull_en(pull_en));

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
         hold_mon = hold_mon & pull_en;
      end
   endtask

   task automatic set_level(input logic v);
      @(negedge clk) hw_level = v;
      idle(3);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      idle(5);
      check("R1 R10 in reset", pull_en, 1'b0);
      rst_n = 1'b1;
      idle(3);
      check("R1 after reset", pull_en, 1'b0);
   endtask

   task automatic t_qualify_width;
      set_level(1'b1);
      ticks(DG - 1);
      check("R2 before deglitch done", pull_en, 1'b0);
      ticks(1);
      check("R2 accepted", pull_en, 1'b1);
      ticks(PW - 1);
      check("R4 last tick pending", pull_en, 1'b1);
      ticks(1);
      check("R4 pulse ended", pull_en, 1'b0);
   endtask

   task automatic t_hold_high;
      ticks(3 * PW);
      check("R5 level held high", pull_en, 1'b0);
      set_level(1'b0);
   endtask

   task automatic t_early_drop;
      set_level(1'b1);
      ticks(DG - 1);
      set_level(1'b0);
      ticks(2);
      check("R3 low ticks ignored", pull_en, 1'b0);
      set_level(1'b1);
      ticks(DG - 1);
      check("R3 count restarted", pull_en, 1'b0);
      ticks(1);
      check("R3 full period accepted", pull_en, 1'b1);
      ticks(PW);
      check("R3 pulse ended", pull_en, 1'b0);
      set_level(1'b0);
   endtask

   task automatic t_retrigger;
      set_level(1'b1);
      ticks(DG);
      check("R7 first pulse", pull_en, 1'b1);
      ticks(2);
      set_level(1'b0);
      set_level(1'b1);
      hold_mon = 1'b1;
      ticks(DG);
      ticks(PW - 1);
      check("R7 no release between pulses", hold_mon, 1'b1);
      check("R7 width from new event", pull_en, 1'b1);
      ticks(1);
      check("R7 extended pulse ended", pull_en, 1'b0);
      set_level(1'b0);
   endtask

   task automatic t_fault;
      @(negedge clk) fault_stb = 1'b1;
      @(negedge clk) fault_stb = 1'b0;
      check("R6 fault starts pulse", pull_en, 1'b1);
      ticks(PW - 1);
      check("R6 fault pulse running", pull_en, 1'b1);
      ticks(1);
      check("R6 fault pulse ended", pull_en, 1'b0);
      @(negedge clk) fault_stb = 1'b1;
      @(negedge clk) fault_stb = 1'b0;
      ticks(5);
      @(negedge clk) fault_stb = 1'b1;
      @(negedge clk) fault_stb = 1'b0;
      ticks(PW - 1);
      check("R6 fault restart full width", pull_en, 1'b1);
      ticks(1);
      check("R6 restarted pulse ended", pull_en, 1'b0);
   endtask

   task automatic t_same_cycle;
      set_level(1'b1);
      ticks(DG - 1);
      @(negedge clk) begin tick = 1'b1; fault_stb = 1'b1; end
      @(negedge clk) begin tick = 1'b0; fault_stb = 1'b0; end
      check("R8 joint start", pull_en, 1'b1);
      ticks(PW - 1);
      check("R8 single width running", pull_en, 1'b1);
      ticks(1);
      check("R8 single width ended", pull_en, 1'b0);
      set_level(1'b0);
   endtask

   task automatic t_event_on_tick;
      @(negedge clk) fault_stb = 1'b1;
      @(negedge clk) fault_stb = 1'b0;
      ticks(PW - 3);
      @(negedge clk) begin tick = 1'b1; fault_stb = 1'b1; end
      @(negedge clk) begin tick = 1'b0; fault_stb = 1'b0; end
      ticks(PW - 1);
      check("R9 coincident tick not consumed", pull_en, 1'b1);
      ticks(1);
      check("R9 pulse ended", pull_en, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_qualify_width();
      t_hold_high();
      t_early_drop();
      t_retrigger();
      t_fault();
      t_same_cycle();
      t_event_on_tick();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule